// File: doc/BRIEF.md
# Flexible-Length Serial Stereo Audio Receiver

This block turns a time-multiplexed serial stereo stream into two parallel 16-bit codes for a dual-channel current-steering converter. The stream uses three signals: a bit clock, a word-select line and one data line. The logic runs in the bit-clock domain. Data and word select are sampled on every rising edge of `bit_clk`.

Each sample word is two's complement and arrives most significant bit first. A word may be any number of bits long. The receiver places the first bit of each word at bit 15 and fills downward. Bits after the sixteenth are dropped. Low bits that a short word never reaches stay at zero.

When the stream passes from a right word to a left word, the receiver copies both channels into their output registers on the same edge. It inverts the most significant bit on the way, which gives the offset code the switch array expects, and it raises a one-cycle strobe.

Top module: `i2s_stereo_rx`

## Requirements
- R1: A 16-bit word sent MSB first appears on the output with its first serial bit at bit 15 and its last serial bit at bit 0.
- R2: In a word longer than 16 bits, every bit after the sixteenth is discarded and does not affect the output.
- R3: In a word shorter than 16 bits, the received bits fill from bit 15 downward and every bit position not reached is 0.
- R4: Bits sampled while `word_sel` is 0 form the left word. Bits sampled while `word_sel` is 1 form the right word.
- R5: Both output codes are updated on the one rising edge at which `word_sel` is first sampled 0 after being sampled 1. `pair_valid` is 1 for exactly that one cycle.
- R6: Each output code equals the received two's-complement word with bit 15 inverted. Data 8000h gives 0000h, data 0000h gives 8000h, and data 7FFFh gives FFFFh.
- R7: After reset both codes are 8000h, which is data 0000h (bipolar zero), and `pair_valid` is 0.
- R8: No transfer takes place until a left word and the right word after it have both been received whole, each starting at a `word_sel` change. A left word already in progress when reset is released is never delivered.
- R9: Between transfers both output codes hold their values and `pair_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| word_sel | input | 1 | Channel select: 0 = left, 1 = right; a change starts a new word |
| ser_data | input | 1 | Serial data, two's complement, MSB first |
| left_code | output | 16 | Left channel switch code (offset binary) |
| right_code | output | 16 | Right channel switch code (offset binary) |
| pair_valid | output | 1 | One-cycle pulse when both codes are updated |

## Verification
A bit pointer that is wrong shifts the word or smears it. The fault shows at the next transfer, one bit-clock period after the right word ends, as a code moved left or right or with nonzero low bits.

A wrong word-select edge tracker shows in one of two ways. A strobe may appear in the middle of a word, which the per-cycle hold check catches at once. Or a strobe may be missing at a left-word start, which the next comparison catches.

A missing MSB inversion shows on the first transfer as a code that differs in bit 15.

Sweeping both channels over short, exact and long word lengths exposes each of these faults within one stereo frame.

// File: rtl/i2s_rx_pkg.sv
package i2s_rx_pkg;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;

  localparam int NUM_CH = 2;

endpackage

// File: rtl/i2s_rx_frame_ctrl.sv
module i2s_rx_frame_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic ws,
  output logic word_start,
  output logic pair_load
);
  import i2s_rx_pkg::*;

  logic seen_q;
  logic ws_prev_q;
  logic synced_q;
  logic left_ok_q;

  assign word_start = seen_q && (ws != ws_prev_q);
  assign pair_load  = word_start && (ws == CH_LEFT) && left_ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q    <= 1'b0;
      ws_prev_q <= 1'b0;
      synced_q  <= 1'b0;
      left_ok_q <= 1'b0;
    end else begin
      seen_q    <= 1'b1;
      ws_prev_q <= ws;
      if (word_start) begin
        synced_q <= 1'b1;
        if (ws == CH_RIGHT) begin
          left_ok_q <= synced_q;
        end
      end
    end
  end

  // R8: a transfer needs word tracking locked by an earlier change
  a_r8_load_after_sync: assert property (@(posedge clk) disable iff (rst)
    pair_load |-> synced_q);

  // R5: once locked, the tracker stays locked until reset
  a_r5_sync_sticky: assert property (@(posedge clk) disable iff (rst)
    synced_q |=> synced_q);

endmodule

// File: rtl/i2s_rx_slot.sv
module i2s_rx_slot #(
  parameter int   WORD_W = 16,
  parameter logic CHAN   = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ws,
  input  logic              word_start,
  input  logic              sd,
  output logic [WORD_W-1:0] word
);
  localparam int PTR_W = $clog2(WORD_W + 1);
  localparam logic [PTR_W-1:0] PTR_FULL = PTR_W'(WORD_W);

  logic             active;
  logic [PTR_W-1:0] ptr_q;

  assign active = (ws == CHAN);

  always_ff @(posedge clk) begin
    if (rst) begin
      word  <= '0;
      ptr_q <= PTR_FULL;
    end else if (active) begin
      if (word_start) begin
        word  <= {sd, {(WORD_W-1){1'b0}}};
        ptr_q <= PTR_W'(1);
      end else if (ptr_q < PTR_FULL) begin
        for (int i = 0; i < WORD_W; i++) begin
          if (ptr_q == PTR_W'(WORD_W - 1 - i)) begin
            word[i] <= sd;
          end
        end
        ptr_q <= ptr_q + PTR_W'(1);
      end
    end
  end

  // R2: the pointer never passes the word width
  a_r2_ptr_bound: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= PTR_FULL);

  // R3: a new word starts at the MSB with all lower bits cleared
  a_r3_msb_start: assert property (@(posedge clk) disable iff (rst)
    (active && word_start) |=> (word[WORD_W-1] == $past(sd)) && (word[WORD_W-2:0] == '0));

  // R2: bits after the last position leave the register alone
  a_r2_drop_extra: assert property (@(posedge clk) disable iff (rst)
    (active && !word_start && ptr_q == PTR_FULL) |=> $stable(word));

  // R4: the other channel's bits never touch this register
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !active |=> $stable(word));

endmodule

// File: rtl/i2s_rx_code_out.sv
module i2s_rx_code_out #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word_l,
  input  logic [WORD_W-1:0] word_r,
  output logic [WORD_W-1:0] code_l,
  output logic [WORD_W-1:0] code_r,
  output logic              valid
);
  localparam logic [WORD_W-1:0] MSB_MASK = {1'b1, {(WORD_W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      code_l <= MSB_MASK;
      code_r <= MSB_MASK;
      valid  <= 1'b0;
    end else begin
      valid <= load;
      if (load) begin
        code_l <= word_l ^ MSB_MASK;
        code_r <= word_r ^ MSB_MASK;
      end
    end
  end

  // R9: codes hold whenever no transfer is requested
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(code_l) && $stable(code_r)));

  // R5: the strobe lasts a single cycle
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  // R6: the top bit of each code is the inverse of the data sign bit
  a_r6_sign_flip: assert property (@(posedge clk) disable iff (rst)
    load |=> (code_l[WORD_W-1] != $past(word_l[WORD_W-1])) &&
             (code_r[WORD_W-1] != $past(word_r[WORD_W-1])));

endmodule

// File: rtl/i2s_stereo_rx.sv
module i2s_stereo_rx #(
  parameter int WORD_W = 16
) (
  input  logic              bit_clk,
  input  logic              rst,
  input  logic              word_sel,
  input  logic              ser_data,
  output logic [WORD_W-1:0] left_code,
  output logic [WORD_W-1:0] right_code,
  output logic              pair_valid
);
  import i2s_rx_pkg::*;

  logic              word_start;
  logic              pair_load;
  logic [WORD_W-1:0] words [NUM_CH];

  i2s_rx_frame_ctrl u_ctrl (
    .clk        (bit_clk),
    .rst        (rst),
    .ws         (word_sel),
    .word_start (word_start),
    .pair_load  (pair_load)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
    i2s_rx_slot #(
      .WORD_W (WORD_W),
      .CHAN   (1'(c))
    ) u_slot (
      .clk        (bit_clk),
      .rst        (rst),
      .ws         (word_sel),
      .word_start (word_start),
      .sd         (ser_data),
      .word       (words[c])
    );
  end

  i2s_rx_code_out #(
    .WORD_W (WORD_W)
  ) u_out (
    .clk    (bit_clk),
    .rst    (rst),
    .load   (pair_load),
    .word_l (words[CH_LEFT]),
    .word_r (words[CH_RIGHT]),
    .code_l (left_code),
    .code_r (right_code),
    .valid  (pair_valid)
  );

  // R5: a strobe follows an edge that saw 0 after an edge that saw 1
  a_r5_strobe_on_fall: assert property (@(posedge bit_clk) disable iff (rst)
    pair_valid |-> (!$past(word_sel) && $past(word_sel, 2)));

endmodule

// File: tb/i2s_stereo_rx_tb_top.sv
module i2s_stereo_rx_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic bit_clk = 1'b0;
  logic rst = 1'b1;
  logic word_sel = 1'b0;
  logic ser_data = 1'b0;
  logic [W-1:0] left_code, right_code;
  logic pair_valid;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] held_l = 16'h8000, held_r = 16'h8000;
  logic [15:0] pend_l, pend_r, last_left;
  bit pend = 1'b0;

  i2s_stereo_rx #(.WORD_W(W)) dut_i (
    .bit_clk    (bit_clk),
    .rst        (rst),
    .word_sel   (word_sel),
    .ser_data   (ser_data),
    .left_code  (left_code),
    .right_code (right_code),
    .pair_valid (pair_valid)
  );

  always #(CLK_PERIOD/2) bit_clk = ~bit_clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic logic [15:0] align(logic [31:0] d, int len);
    if (len >= 16) return 16'(d >> (len - 16));
    else           return 16'(d << (16 - len));
  endfunction

  function automatic logic [31:0] gen(int idx, int len);
    logic [31:0] m;
    m = (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 32'h1);
    return (32'hA5C3_5E17 ^ (32'(idx) * 32'h9E37_79B9)) & m;
  endfunction

  // Called at a falling edge; every bit is sampled at the next rising edge
  task automatic send_word(logic ch, logic [31:0] d, int len);
    bit bad = 1'b0;
    bit xfer = 1'b0;
    for (int i = 0; i < len; i++) begin
      word_sel = ch;
      ser_data = d[len-1-i];
      @(negedge bit_clk);
      if (i == 0 && ch == 1'b0 && pend) begin
        xfer = 1'b1;
        chk("R5 strobe at left start", 32'(pair_valid), 32'h1);
        chk("R1 R2 R3 R4 R6 left code", 32'(left_code), 32'(pend_l));
        chk("R1 R2 R3 R4 R6 right code", 32'(right_code), 32'(pend_r));
        held_l = pend_l;
        held_r = pend_r;
        pend = 1'b0;
      end else if (pair_valid !== 1'b0 || left_code !== held_l || right_code !== held_r) begin
        bad = 1'b1;
      end
    end
    if (!xfer || len > 1) chk("R9 hold and no stray strobe", 32'(bad), 32'h0);
  endtask

  task automatic send_pair(logic [31:0] ld, int ll, logic [31:0] rd, int rl);
    send_word(1'b0, ld, ll);
    send_word(1'b1, rd, rl);
    pend   = 1'b1;
    pend_l = align(ld, ll) ^ 16'h8000;
    pend_r = align(rd, rl) ^ 16'h8000;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int lens[8] = '{1, 4, 8, 15, 16, 17, 24, 32};
    int idx = 0;
    repeat (3) @(negedge bit_clk);
    rst = 1'b0;
    @(negedge bit_clk);
    // R7: reset values
    chk("R7 left reset", 32'(left_code), 32'h8000);
    chk("R7 right reset", 32'(right_code), 32'h8000);
    chk("R7 strobe reset", 32'(pair_valid), 32'h0);

    // R8: left word in progress at reset, then an unpaired right word
    send_word(1'b0, 32'h5, 3);
    send_word(1'b1, 32'h1234, 16);
    send_word(1'b0, 32'h7777, 16);
    chk("R8 no transfer before full pair, left", 32'(left_code), 32'h8000);
    chk("R8 no transfer before full pair, right", 32'(right_code), 32'h8000);
    send_word(1'b1, 32'h2222, 16);
    // R8: the first complete pair (7777h, 2222h) is delivered next
    pend = 1'b1;
    pend_l = 16'h7777 ^ 16'h8000;
    pend_r = 16'h2222 ^ 16'h8000;

    // R6: fixed code points
    send_pair(32'h8000, 16, 32'h0000, 16);
    send_pair(32'h7FFF, 16, 32'hFFFF, 16);
    send_pair(32'h0001, 16, 32'hFFFE, 16);

    // R1 R2 R3 R4: sweep of word lengths on both channels
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        send_pair(gen(idx, lens[a]), lens[a], gen(idx + 1000, lens[b]), lens[b]);
        idx++;
      end
    end
    send_word(1'b0, 32'h0, 4);

    summary();
    $finish;
  end

endmodule